// File: doc/BRIEF.md
# Vector Byte Permute Unit

This unit rearranges bytes of 128-bit vectors. Each operation takes two 16-byte sources, A and B, and produces one 16-byte result. Every result byte is picked from the 32 bytes of the concatenation A‖B by one shared crossbar. Byte 0 is the most-significant byte of each bus. Bytes 0..15 of A‖B are A's bytes and bytes 16..31 are B's bytes.

A general permute takes its per-byte indices from a third vector, C. All other operations are fixed index patterns that the same crossbar applies:

- immediate shift-double;
- element splat;
- merge-high and merge-low at byte, halfword and word size.

The one exception is the splat of a signed literal, which places constant bytes in the result instead of source bytes. An unrecognised opcode forces a zero result.

The unit accepts one operation per cycle and registers the result, so it has a single cycle of latency. The instruction decoder outside the unit supplies the opcode and the immediate.

Top module: `vperm_unit`

## Requirements
- R1: While reset is asserted and after it is released with no operation issued, out_valid is 0 and result is all zeros.
- R2: Every cycle with in_valid high produces out_valid high with the matching result on the next cycle. A cycle without in_valid gives out_valid low on the next cycle, and result keeps its previous value.
- R3: Opcode 0 (permute): result byte k is byte (C byte k AND 0x1F) of A‖B. The upper three bits of every control byte have no effect.
- R4: Opcode 1 (shift-double): with n = imm[3:0], the result is bytes n through n+15 of A‖B. n = 0 returns A unchanged.
- R5: Opcode 1 covers the derived whole-vector forms. With A equal to B it rotates A left by 8n bits. With B zero it shifts A left by 8n bits. With A zero and n = 16−k it shifts B right by 8k bits.
- R6: Opcodes 2, 3 and 4 (splat byte, halfword, word): every element of the result equals element e of B. Here e = imm modulo the element count, and element 0 is the most-significant element.
- R7: Opcodes 5, 6 and 7 (literal splat byte, halfword, word): every element equals imm read as a 5-bit two's-complement value (−16..15), sign-extended to the element width.
- R8: Opcodes 8, 9 and 10 (merge-high byte, halfword, word): result element 2j is element j of A, and result element 2j+1 is element j of B, for the first half of the elements.
- R9: Opcodes 11, 12 and 13 (merge-low byte, halfword, word): the same interleave as R8, but the elements are taken from the second half of A and of B.
- R10: Opcodes 14 and 15 yield an all-zero result, and out_valid is still asserted one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 4 | Opcode, encodings as in R3–R10 |
| opa | input | 128 | Source A, byte 0 in bits 127:120 |
| opb | input | 128 | Source B |
| opc | input | 128 | Permute control vector |
| imm | input | 5 | Shift count, element number or signed literal |
| out_valid | output | 1 | Result valid |
| result | output | 128 | Registered result |

## Verification
The bench attacks the byte numbering first: a little-endian crossbar would mirror every permute and shift result, and the asymmetric byte patterns make that mirroring visible. Control bytes are driven with their upper three bits set. A design that decodes those bits would fetch out-of-range or zero bytes.

Splat and literal-splat immediates are driven beyond the element count and at both ends of the signed range. A design that fails to wrap the element number or to sign-extend the literal would return the wrong element or a positive value. Merge-low is run at all three element sizes to expose a half-vector offset applied at the wrong granularity.

Back-to-back issue with idle gaps catches a result that is not held between operations, and a valid that lags or leaks. Illegal opcodes are checked to confirm they zero the result rather than pass a stale crossbar output.

// File: rtl/vperm_pkg.sv
package vperm_pkg;

  typedef enum logic [3:0] {
    OP_PERM    = 4'd0,
    OP_SLDI    = 4'd1,
    OP_SPLT_B  = 4'd2,
    OP_SPLT_H  = 4'd3,
    OP_SPLT_W  = 4'd4,
    OP_SPLI_B  = 4'd5,
    OP_SPLI_H  = 4'd6,
    OP_SPLI_W  = 4'd7,
    OP_MRGH_B  = 4'd8,
    OP_MRGH_H  = 4'd9,
    OP_MRGH_W  = 4'd10,
    OP_MRGL_B  = 4'd11,
    OP_MRGL_H  = 4'd12,
    OP_MRGL_W  = 4'd13,
    OP_BAD0    = 4'd14,
    OP_BAD1    = 4'd15
  } vp_op_e;

  // Element size in bytes for the sized opcodes; 1 otherwise.
  function automatic int elem_bytes(vp_op_e op);
    case (op)
      OP_SPLT_H, OP_SPLI_H, OP_MRGH_H, OP_MRGL_H: return 2;
      OP_SPLT_W, OP_SPLI_W, OP_MRGH_W, OP_MRGL_W: return 4;
      default:                                    return 1;
    endcase
  endfunction

  function automatic logic op_is_illegal(vp_op_e op);
    return (op == OP_BAD0) || (op == OP_BAD1);
  endfunction

  // Source byte (0..nb-1 within B) for output byte k of a splat of element e.
  function automatic int splat_pos(int k, int s, int e, int nb);
    return (e % (nb / s)) * s + (k % s);
  endfunction

  // Index into A||B for output byte k of a merge of element size s.
  function automatic int merge_pos(int k, int s, int nb, logic low_half);
    int j;
    j = k / s;
    return (j % 2) * nb + (j / 2) * s + (low_half ? nb / 2 : 0) + (k % s);
  endfunction

endpackage

// File: rtl/vperm_ctrl.sv
module vperm_ctrl
  import vperm_pkg::*;
#(
  parameter int NB   = 16,
  parameter int IW   = 5,
  localparam int IDXW = $clog2(2 * NB),
  localparam int SHW  = $clog2(NB)
) (
  input  vp_op_e                   op,
  input  logic [NB*8-1:0]          ctl,
  input  logic [IW-1:0]            imm,
  output logic [NB-1:0][IDXW-1:0]  idx,
  output logic [NB-1:0]            lit_en,
  output logic [NB-1:0][7:0]       lit_byte,
  output logic [NB-1:0]            zero_en
);

  generate
    for (genvar k = 0; k < NB; k++) begin : g_byte
      logic [7:0] cbyte;
      int         s;
      assign cbyte = ctl[(NB-1-k)*8 +: 8];

      always_comb begin
        s           = elem_bytes(op);
        idx[k]      = '0;
        lit_en[k]   = 1'b0;
        lit_byte[k] = '0;
        zero_en[k]  = 1'b0;
        case (op)
          OP_PERM: idx[k] = IDXW'(cbyte);
          OP_SLDI: idx[k] = IDXW'(k + int'(imm[SHW-1:0]));
          OP_SPLT_B, OP_SPLT_H, OP_SPLT_W:
            idx[k] = IDXW'(NB + splat_pos(k, s, int'(imm), NB));
          OP_SPLI_B, OP_SPLI_H, OP_SPLI_W: begin
            lit_en[k]   = 1'b1;
            lit_byte[k] = ((k % s) == s - 1) ? 8'($signed(imm)) : {8{imm[IW-1]}};
          end
          OP_MRGH_B, OP_MRGH_H, OP_MRGH_W:
            idx[k] = IDXW'(merge_pos(k, s, NB, 1'b0));
          OP_MRGL_B, OP_MRGL_H, OP_MRGL_W:
            idx[k] = IDXW'(merge_pos(k, s, NB, 1'b1));
          default: zero_en[k] = 1'b1;
        endcase
      end
    end
  endgenerate

endmodule

// File: rtl/vperm_xbar.sv
module vperm_xbar #(
  parameter int NB   = 16,
  localparam int IDXW = $clog2(2 * NB)
) (
  input  logic [2*NB*8-1:0]        cat,
  input  logic [NB-1:0][IDXW-1:0]  idx,
  input  logic [NB-1:0]            lit_en,
  input  logic [NB-1:0][7:0]       lit_byte,
  input  logic [NB-1:0]            zero_en,
  output logic [NB*8-1:0]          res
);

  logic [2*NB-1:0][7:0] src_b;
  logic [NB-1:0][7:0]   out_b;

  assign src_b = cat;
  assign res   = out_b;

  generate
    for (genvar k = 0; k < NB; k++) begin : g_mux
      always_comb begin
        if (zero_en[k])     out_b[NB-1-k] = '0;
        else if (lit_en[k]) out_b[NB-1-k] = lit_byte[k];
        else                out_b[NB-1-k] = src_b[2*NB-1-int'(idx[k])];
      end
    end
  endgenerate

endmodule

// File: rtl/vperm_unit.sv
module vperm_unit
  import vperm_pkg::*;
#(
  parameter int NB = 16,
  parameter int IW = 5,
  localparam int W    = NB * 8,
  localparam int IDXW = $clog2(2 * NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [3:0]    op,
  input  logic [W-1:0]  opa,
  input  logic [W-1:0]  opb,
  input  logic [W-1:0]  opc,
  input  logic [IW-1:0] imm,
  output logic          out_valid,
  output logic [W-1:0]  result
);

  vp_op_e                  op_e;
  logic [NB-1:0][IDXW-1:0] idx;
  logic [NB-1:0]           lit_en;
  logic [NB-1:0][7:0]      lit_byte;
  logic [NB-1:0]           zero_en;
  logic [W-1:0]            xbar_out;
  logic                    illegal_op;

  assign op_e       = vp_op_e'(op);
  assign illegal_op = op_is_illegal(op_e);

  vperm_ctrl #(.NB(NB), .IW(IW)) u_ctrl (
    .op(op_e), .ctl(opc), .imm(imm),
    .idx(idx), .lit_en(lit_en), .lit_byte(lit_byte), .zero_en(zero_en)
  );

  vperm_xbar #(.NB(NB)) u_xbar (
    .cat({opa, opb}), .idx(idx), .lit_en(lit_en), .lit_byte(lit_byte),
    .zero_en(zero_en), .res(xbar_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= xbar_out;
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result)));

  // R10
  illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && illegal_op) |=> (result == '0));

  // R4
  sldi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_e == OP_SLDI && imm[$clog2(NB)-1:0] == '0) |=> (result == $past(opa)));

  // R3
  perm_bcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_e == OP_PERM && opc == '0) |=> (result == {NB{$past(opa[W-1 -: 8])}}));

endmodule

// File: tb/vperm_unit_bench.sv
module vperm_unit_bench;

  typedef struct {
    logic [127:0] v;
    int           cyc;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [3:0]   op = '0;
  logic [127:0] opa = '0, opb = '0, opc = '0;
  logic [4:0]   imm = '0;
  logic         out_valid;
  logic [127:0] result;

  int checks = 0, fails = 0, cyc = 0;
  bit started = 0, finished = 0;
  exp_t q[$];
  logic [127:0] last_res = '0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  vperm_unit u_vperm_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .opa(opa), .opb(opb), .opc(opc), .imm(imm),
    .out_valid(out_valid), .result(result)
  );

  function automatic logic [127:0] elem_of(logic [127:0] v, int s, int e);
    logic [127:0] t;
    t = v >> (128 - 8 * s * (e + 1));
    return t & ((128'd1 << (8 * s)) - 1);
  endfunction

  function automatic logic [127:0] model(int o, logic [127:0] a, logic [127:0] b,
                                         logic [127:0] c, logic [4:0] im);
    logic [255:0] cat;
    logic [127:0] r, el;
    int s, ne;
    cat = {a, b};
    r = '0;
    s = (o inside {3, 6, 9, 12}) ? 2 : (o inside {4, 7, 10, 13}) ? 4 : 1;
    ne = 16 / s;
    case (o)
      0: for (int k = 0; k < 16; k++) begin
           int i;
           i = int'(c[127 - 8*k -: 8]) % 32;
           r[127 - 8*k -: 8] = cat[255 - 8*i -: 8];
         end
      1: r = cat[255 - 8 * int'(im[3:0]) -: 128];
      2, 3, 4: begin
           el = elem_of(b, s, int'(im) % ne);
           for (int j = 0; j < ne; j++) r = (r << (8*s)) | el;
         end
      5, 6, 7: begin
           el = 128'($signed(im)) & ((128'd1 << (8*s)) - 1);
           for (int j = 0; j < ne; j++) r = (r << (8*s)) | el;
         end
      8, 9, 10, 11, 12, 13:
         for (int j = 0; j < ne; j++) begin
           int e;
           e = j / 2 + ((o >= 11) ? ne / 2 : 0);
           el = elem_of((j % 2) ? b : a, s, e);
           r = (r << (8*s)) | el;
         end
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic issue(int o, logic [127:0] a, logic [127:0] b, logic [127:0] c,
                       logic [4:0] im, string tag, logic [127:0] exp_override = 'x,
                       bit use_override = 0);
    exp_t it;
    @(negedge clk);
    in_valid = 1'b1; op = 4'(o); opa = a; opb = b; opc = c; imm = im;
    it.v = use_override ? exp_override : model(o, a, b, c, im);
    it.cyc = cyc;
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      opa = ~opa;
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      if (out_valid) begin
        exp_t it;
        checks++;
        if (q.size() == 0) begin
          fails++;
          $display("FAIL R2 unexpected out_valid result=%h expected=no output", result);
        end else begin
          it = q.pop_front();
          if (result !== it.v || cyc != it.cyc + 1) begin
            fails++;
            $display("FAIL %s result=%h cyc=%0d expected=%h cyc=%0d",
                     it.tag, result, cyc, it.v, it.cyc + 1);
          end
        end
      end else begin
        checks++;
        if (result !== last_res) begin
          fails++;
          $display("FAIL R2 hold result=%h expected=%h", result, last_res);
        end
      end
      last_res = result;
    end
  end

  localparam logic [127:0] PA = 128'hA0A1A2A3A4A5A6A7A8A9AAABACADAEAF;
  localparam logic [127:0] PB = 128'hB0B1B2B3B4B5B6B7B8B9BABBBCBDBEBF;

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || result !== '0) begin
      fails++;
      $display("FAIL R1 reset out_valid=%b result=%h expected=0/0", out_valid, result);
    end
    rst_n = 1'b1;
    @(negedge clk);
    started = 1;
    idle(2);
    // R3 permute, including control bytes with upper bits set
    issue(0, PA, PB, 128'h00160F1A0A170C1F081D1E1C05150014, 5'd0, "R3 perm");
    issue(0, PA, PB, 128'hE0F6EFFA2A376C9F48BDDE1CA5F500F4, 5'd0, "R3 perm hibits");
    issue(0, PA, PB, 128'h1F1E1D1C1B1A19181716151413121110, 5'd0, "R3 perm reverse");
    issue(0, PA, PB, '0, 5'd0, "R3 perm bcast");
    // R4 shift-double
    issue(1, PA, PB, '0, 5'd4, "R4 sldi4", 128'hA4A5A6A7A8A9AAABACADAEAFB0B1B2B3, 1);
    issue(1, PA, PB, '0, 5'd0, "R4 sldi0", PA, 1);
    issue(1, PA, PB, '0, 5'd15, "R4 sldi15");
    idle(2);
    // R5 derived forms
    issue(1, PA, PA, '0, 5'd3, "R5 rotate", {PA[103:0], PA[127:104]}, 1);
    issue(1, PA, '0, '0, 5'd5, "R5 lshift", PA << 40, 1);
    issue(1, '0, PB, '0, 5'd13, "R5 rshift", PB >> 24, 1);
    // R6 splat
    issue(2, PA, PB, '0, 5'd9, "R6 splat b", {16{8'hB9}}, 1);
    issue(3, PA, PB, '0, 5'd3, "R6 splat h", {8{16'hB6B7}}, 1);
    issue(4, PA, PB, '0, 5'd6, "R6 splat w wrap", {4{32'hB8B9BABB}}, 1);
    issue(2, PA, PB, '0, 5'd31, "R6 splat b wrap");
    // R7 literal splat
    issue(5, PA, PB, '0, 5'h10, "R7 lit b -16", {16{8'hF0}}, 1);
    issue(6, PA, PB, '0, 5'h0F, "R7 lit h 15", {8{16'h000F}}, 1);
    issue(7, PA, PB, '0, 5'h1F, "R7 lit w -1", {128{1'b1}}, 1);
    issue(6, PA, PB, '0, 5'h11, "R7 lit h -15");
    idle(1);
    // R8 merge high
    issue(8, PA, PB, '0, 5'd0, "R8 mrgh b", 128'hA0B0A1B1A2B2A3B3A4B4A5B5A6B6A7B7, 1);
    issue(9, PA, PB, '0, 5'd0, "R8 mrgh h");
    issue(10, PA, PB, '0, 5'd0, "R8 mrgh w", 128'hA0A1A2A3B0B1B2B3A4A5A6A7B4B5B6B7, 1);
    // R9 merge low
    issue(11, PA, PB, '0, 5'd0, "R9 mrgl b", 128'hA8B8A9B9AABAABBBACBCADBDAEBEAFBF, 1);
    issue(12, PA, PB, '0, 5'd0, "R9 mrgl h", 128'hA8A9B8B9AAABBABBACADBCBDAEAFBEBF, 1);
    issue(13, PA, PB, '0, 5'd0, "R9 mrgl w");
    // R10 illegal
    issue(14, PA, PB, PA, 5'd7, "R10 illegal14", '0, 1);
    idle(1);
    issue(0, PA, PB, 128'h05050505050505050505050505050505, 5'd0, "R3 perm pre");
    issue(15, PA, PB, PB, 5'd3, "R10 illegal15", '0, 1);
    idle(4);
    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R2 missing outputs=%0d expected=0", q.size());
    end
    summary();
  end

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired cycles=%0d expected=completion", cyc);
    summary();
  end

endmodule